// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the host-facing register interface of one eight-input interrupt controller. A simple strobed bus with one address bit and a byte of data sets it up and reads it back. An initialization sequence of three or four bytes sets the vector base and the operating modes. After that, writes load the input mask, issue end-of-interrupt and priority commands, pick which status byte a read returns, and arm a poll. The priority core is a separate block. It takes the configuration levels and the single-cycle command pulses that this block produces, and it returns its pending and in-service vectors and its current winner.

A poll works like this. An operation word arms it, and the next read becomes an acknowledge: the read returns the number of the winning input, and an acknowledge pulse tells the core to drop that input's pending and in-service bits. A separate trigger-mode byte has its own write strobe. It keeps only the bits that a per-instance parameter allows, so the same RTL serves both the cascade master and the slave.

Top module: `irqc_regif`

## Requirements
- R1: After reset, the mask, vector base, nested-mode flag, auto-EOI flag, rotate-on-auto-EOI flag, special mask, trigger-mode register and read data are all zero, and no pulse output is high.
- R2: A write to address 0 with data bit 4 set starts initialization. It clears the mask, the special mask and the read select (back to pending), and it pulses `lvl_clr_p` in the next cycle. If data bit 0 is clear, it also clears the nested-mode and auto-EOI flags.
- R3: The next address-1 write after an initialization start sets the vector base to the data ANDed with 0xF8.
- R4: The address-1 write that follows it is accepted and has no effect on any output. If bit 0 of the starting word was set, one more address-1 write is taken as the fourth word. Otherwise the next address-1 write loads the mask.
- R5: In the fourth word, data bit 4 sets the nested-mode flag and data bit 1 sets the auto-EOI flag.
- R6: Outside initialization, an address-1 write loads the mask. A read at address 1 returns the mask one cycle after the read strobe. The mask never changes in a cycle without a write.
- R7: An address-0 write with bit 4 clear and bit 3 set is an operation word. If bit 1 is set, bit 0 selects what address-0 reads return (0 = pending vector, 1 = in-service vector). If bit 6 is set, bit 5 becomes the special mask. When bit 1 or bit 6 is clear, the matching setting is left unchanged.
- R8: An address-0 write with bits 4 and 3 clear is a command whose code is in bits 7:5. Code 4 sets the rotate-on-auto-EOI flag and code 0 clears it.
- R9: Command codes 1, 5, 3, 6 and 7 each raise exactly one pulse output (non-specific EOI, rotating EOI, specific EOI, set priority, rotate-specific EOI), high for exactly the one cycle after the write. `cmd_level` then carries data bits 2:0. Code 2 raises no pulse.
- R10: Bit 2 of an operation word arms poll mode. The next read then returns the core's winning input number in bits 2:0, with the upper bits zero, and pulses `poll_ack_p` with `poll_ack_id`. If the core reports no winner, the read returns 7 and no acknowledge is sent. Either way poll mode is then cleared.
- R11: A trigger-mode write stores the data ANDed with the parameter `TRIG_MASK` (0xF8 for the master, 0xDE for the slave), and `trig_mode` shows the stored value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pend_i | input | 8 | Pending vector from the core |
| insvc_i | input | 8 | In-service vector from the core |
| win_valid_i | input | 1 | Core has a winning input |
| win_id_i | input | 3 | Number of the winning input |
| trig_wr_en | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data |
| trig_mode | output | 8 | Trigger-mode register (1 = level) |
| mask | output | 8 | Input mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| lvl_clr_p | output | 1 | Pulse: clear the sampled input levels |
| eoi_ns_p | output | 1 | Pulse: non-specific EOI |
| eoi_rot_p | output | 1 | Pulse: rotating non-specific EOI |
| eoi_spec_p | output | 1 | Pulse: specific EOI of `cmd_level` |
| prio_set_p | output | 1 | Pulse: lowest priority becomes `cmd_level` |
| eoi_rspec_p | output | 1 | Pulse: specific EOI of `cmd_level`, then rotate |
| cmd_level | output | 3 | Input number carried by the last command |
| poll_ack_p | output | 1 | Pulse: poll read acknowledged `poll_ack_id` |
| poll_ack_id | output | 3 | Input acknowledged by the poll |

## Verification
The bench builds two copies of the block from the same source. One uses the default `TRIG_MASK` of 0xF8 and the other uses 0xDE, and both sit on one shared bus. Every trigger-mode write therefore checks the bit filtering against both patterns: a bit that one copy keeps and the other drops is seen in both states. All other behaviour, including both initialization paths, all eight command codes and the poll with and without a winner, is checked on the master copy.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SEQ_NORM = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_e;

  typedef enum logic [2:0] {
    CMD_ROT_CLR = 3'd0,
    CMD_NSEOI   = 3'd1,
    CMD_NOP     = 3'd2,
    CMD_SEOI    = 3'd3,
    CMD_ROT_SET = 3'd4,
    CMD_REOI    = 3'd5,
    CMD_SETPRI  = 3'd6,
    CMD_RSEOI   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic nseoi;
    logic reoi;
    logic seoi;
    logic setpri;
    logic rseoi;
  } cmd_pulse_t;

  // Bit positions of the address-0 word that steer decoding
  localparam int unsigned B_INIT    = 4;
  localparam int unsigned B_OPWORD  = 3;
  localparam int unsigned B_POLL    = 2;
  localparam int unsigned B_RSEL_EN = 1;
  localparam int unsigned B_RSEL    = 0;
  localparam int unsigned B_SMM_EN  = 6;
  localparam int unsigned B_SMM     = 5;
  localparam int unsigned B_NEED4   = 0;
  localparam int unsigned B_NESTED  = 4;
  localparam int unsigned B_AEOI    = 1;

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic          nested_mode,
  output logic          auto_eoi,
  output logic          lvl_clr_p
);
  localparam int ID_W = $clog2(DW);
  localparam logic [DW-1:0] BASE_KEEP = {{(DW-ID_W){1'b1}}, {ID_W{1'b0}}};

  seq_e st;
  logic need4;
  logic start_w;

  assign start_w = wr_en && !addr && wdata[B_INIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SEQ_NORM;
      need4       <= 1'b0;
      mask        <= '0;
      vec_base    <= '0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
      lvl_clr_p   <= 1'b0;
    end else begin
      lvl_clr_p <= 1'b0;
      if (start_w) begin
        need4     <= wdata[B_NEED4];
        mask      <= '0;
        lvl_clr_p <= 1'b1;
        st        <= SEQ_W2;
        if (!wdata[B_NEED4]) begin
          nested_mode <= 1'b0;
          auto_eoi    <= 1'b0;
        end
      end else if (wr_en && addr) begin
        case (st)
          SEQ_NORM: mask <= wdata;
          SEQ_W2: begin
            vec_base <= wdata & BASE_KEEP;
            st       <= SEQ_W3;
          end
          SEQ_W3: st <= need4 ? SEQ_W4 : SEQ_NORM;
          SEQ_W4: begin
            nested_mode <= wdata[B_NESTED];
            auto_eoi    <= wdata[B_AEOI];
            st          <= SEQ_NORM;
          end
          default: st <= SEQ_NORM;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_sel,
  output logic          special_mask,
  output logic          rot_aeoi,
  output logic          poll_arm,
  output cmd_pulse_t    pulses,
  output logic [2:0]    cmd_level
);
  logic init_w, op_w, cmd_w;
  cmd_e code;

  assign init_w   = wr_en && !addr && wdata[B_INIT];
  assign op_w     = wr_en && !addr && !wdata[B_INIT] && wdata[B_OPWORD];
  assign cmd_w    = wr_en && !addr && !wdata[B_INIT] && !wdata[B_OPWORD];
  assign code     = cmd_e'(wdata[7:5]);
  assign poll_arm = op_w && wdata[B_POLL];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel       <= 1'b0;
      special_mask <= 1'b0;
      rot_aeoi     <= 1'b0;
      pulses       <= '0;
      cmd_level    <= '0;
    end else begin
      pulses <= '0;
      if (init_w) begin
        rd_sel       <= 1'b0;
        special_mask <= 1'b0;
      end
      if (op_w) begin
        if (wdata[B_RSEL_EN]) rd_sel <= wdata[B_RSEL];
        if (wdata[B_SMM_EN])  special_mask <= wdata[B_SMM];
      end
      if (cmd_w) begin
        cmd_level <= wdata[2:0];
        case (code)
          CMD_ROT_CLR: rot_aeoi      <= 1'b0;
          CMD_ROT_SET: rot_aeoi      <= 1'b1;
          CMD_NSEOI:   pulses.nseoi  <= 1'b1;
          CMD_REOI:    pulses.reoi   <= 1'b1;
          CMD_SEOI:    pulses.seoi   <= 1'b1;
          CMD_SETPRI:  pulses.setpri <= 1'b1;
          CMD_RSEOI:   pulses.rseoi  <= 1'b1;
          default:     ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_rd_path.sv
module irqc_rd_path #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic                  addr,
  input  logic                  rd_sel,
  input  logic                  poll_arm,
  input  logic [DW-1:0]         pend_i,
  input  logic [DW-1:0]         insvc_i,
  input  logic [DW-1:0]         mask,
  input  logic                  win_valid_i,
  input  logic [$clog2(DW)-1:0] win_id_i,
  output logic [DW-1:0]         rdata,
  output logic                  poll_ack_p,
  output logic [$clog2(DW)-1:0] poll_ack_id
);
  localparam int ID_W = $clog2(DW);
  localparam logic [DW-1:0] SPURIOUS = DW'(DW - 1);

  logic poll_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      poll_f      <= 1'b0;
      poll_ack_p  <= 1'b0;
      poll_ack_id <= '0;
    end else begin
      poll_ack_p <= 1'b0;
      if (rd_en) begin
        if (poll_f) begin
          poll_f <= 1'b0;
          if (win_valid_i) begin
            rdata       <= {{(DW-ID_W){1'b0}}, win_id_i};
            poll_ack_p  <= 1'b1;
            poll_ack_id <= win_id_i;
          end else begin
            rdata <= SPURIOUS;
          end
        end else if (addr) begin
          rdata <= mask;
        end else begin
          rdata <= rd_sel ? insvc_i : pend_i;
        end
      end
      if (poll_arm) poll_f <= 1'b1;
    end
  end
endmodule

// File: rtl/irqc_trig_reg.sv
module irqc_trig_reg #(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] TRIG_MASK = 8'hF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (TRIG_MASK[i]) begin : g_ff
      always_ff @(posedge clk) begin
        if (rst)        q[i] <= 1'b0;
        else if (wr_en) q[i] <= wdata[i];
      end
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] TRIG_MASK = 8'hF8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [DW-1:0]         pend_i,
  input  logic [DW-1:0]         insvc_i,
  input  logic                  win_valid_i,
  input  logic [$clog2(DW)-1:0] win_id_i,
  input  logic                  trig_wr_en,
  input  logic [DW-1:0]         trig_wdata,
  output logic [DW-1:0]         trig_mode,
  output logic [DW-1:0]         mask,
  output logic [DW-1:0]         vec_base,
  output logic                  nested_mode,
  output logic                  auto_eoi,
  output logic                  rot_aeoi,
  output logic                  special_mask,
  output logic                  lvl_clr_p,
  output logic                  eoi_ns_p,
  output logic                  eoi_rot_p,
  output logic                  eoi_spec_p,
  output logic                  prio_set_p,
  output logic                  eoi_rspec_p,
  output logic [2:0]            cmd_level,
  output logic                  poll_ack_p,
  output logic [$clog2(DW)-1:0] poll_ack_id
);
  logic       rd_sel;
  logic       poll_arm;
  cmd_pulse_t pulses;

  irqc_init_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mask(mask), .vec_base(vec_base), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi), .lvl_clr_p(lvl_clr_p)
  );

  irqc_cmd_dec #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_sel(rd_sel), .special_mask(special_mask), .rot_aeoi(rot_aeoi),
    .poll_arm(poll_arm), .pulses(pulses), .cmd_level(cmd_level)
  );

  irqc_rd_path #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rd_sel(rd_sel),
    .poll_arm(poll_arm), .pend_i(pend_i), .insvc_i(insvc_i), .mask(mask),
    .win_valid_i(win_valid_i), .win_id_i(win_id_i), .rdata(rdata),
    .poll_ack_p(poll_ack_p), .poll_ack_id(poll_ack_id)
  );

  irqc_trig_reg #(.DW(DW), .TRIG_MASK(TRIG_MASK)) u_trig (
    .clk(clk), .rst(rst), .wr_en(trig_wr_en), .wdata(trig_wdata), .q(trig_mode)
  );

  assign eoi_ns_p    = pulses.nseoi;
  assign eoi_rot_p   = pulses.reoi;
  assign eoi_spec_p  = pulses.seoi;
  assign prio_set_p  = pulses.setpri;
  assign eoi_rspec_p = pulses.rseoi;
endmodule

// File: rtl/irqc_regif_chk.sv
module irqc_regif_chk #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] TRIG_MASK = 8'hF8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  addr,
  input logic [DW-1:0]         wdata,
  input logic [DW-1:0]         trig_mode,
  input logic [DW-1:0]         mask,
  input logic                  lvl_clr_p,
  input logic                  eoi_ns_p,
  input logic                  eoi_rot_p,
  input logic                  eoi_spec_p,
  input logic                  prio_set_p,
  input logic                  eoi_rspec_p,
  input logic                  poll_ack_p
);
  AST_TRIG_FILTERED: assert property (@(posedge clk) disable iff (rst)
    (trig_mode & ~TRIG_MASK) == '0); // R11

  AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (mask == '0 && lvl_clr_p)); // R2

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask)); // R6

  AST_ONE_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eoi_ns_p, eoi_rot_p, eoi_spec_p, prio_set_p, eoi_rspec_p})); // R9

  AST_NSEOI_ISSUED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'd1) |=> eoi_ns_p); // R9

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    eoi_spec_p |=> !eoi_spec_p); // R9

  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    poll_ack_p |-> $past(rd_en)); // R10
endmodule

bind irqc_regif irqc_regif_chk #(.DW(DW), .TRIG_MASK(TRIG_MASK)) u_chk (.*);

// File: tb/tb_irqc_regif.sv
module tb_irqc_regif;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, pend_i = '0, insvc_i = '0, trig_wdata = '0;
  logic       win_valid_i = 1'b0, trig_wr_en = 1'b0;
  logic [2:0] win_id_i = '0;

  logic [7:0] rdata, trig_mode, mask, vec_base;
  logic       nested_mode, auto_eoi, rot_aeoi, special_mask, lvl_clr_p;
  logic       eoi_ns_p, eoi_rot_p, eoi_spec_p, prio_set_p, eoi_rspec_p, poll_ack_p;
  logic [2:0] cmd_level, poll_ack_id;

  logic [7:0] s_rdata, s_trig, s_mask, s_base;
  logic       s_nest, s_aeoi, s_rot, s_smm, s_lclr, s_ns, s_re, s_se, s_sp, s_rs, s_pa;
  logic [2:0] s_lvl, s_pid;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irqc_regif dut (
    .clk, .rst, .wr_en, .rd_en, .addr, .wdata, .rdata, .pend_i, .insvc_i,
    .win_valid_i, .win_id_i, .trig_wr_en, .trig_wdata, .trig_mode, .mask,
    .vec_base, .nested_mode, .auto_eoi, .rot_aeoi, .special_mask, .lvl_clr_p,
    .eoi_ns_p, .eoi_rot_p, .eoi_spec_p, .prio_set_p, .eoi_rspec_p, .cmd_level,
    .poll_ack_p, .poll_ack_id
  );

  irqc_regif #(.TRIG_MASK(8'hDE)) dut_s (
    .clk, .rst, .wr_en, .rd_en, .addr, .wdata, .rdata(s_rdata), .pend_i, .insvc_i,
    .win_valid_i, .win_id_i, .trig_wr_en, .trig_wdata, .trig_mode(s_trig),
    .mask(s_mask), .vec_base(s_base), .nested_mode(s_nest), .auto_eoi(s_aeoi),
    .rot_aeoi(s_rot), .special_mask(s_smm), .lvl_clr_p(s_lclr), .eoi_ns_p(s_ns),
    .eoi_rot_p(s_re), .eoi_spec_p(s_se), .prio_set_p(s_sp), .eoi_rspec_p(s_rs),
    .cmd_level(s_lvl), .poll_ack_p(s_pa), .poll_ack_id(s_pid)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t rd_q[$];
  logic     rd_d = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each read strobe
  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) begin
    if (rd_d) begin
      if (rd_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL read with no expected item actual=%02h expected=none", rdata);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk); rd_en = 1'b1; addr = a; rd_q.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pv();
    return {3'b0, eoi_ns_p, eoi_rot_p, eoi_spec_p, prio_set_p, eoi_rspec_p};
  endfunction

  task automatic cmd(input logic [7:0] d, input logic [7:0] exp_p, input string tag);
    wr(1'b0, d);
    check({tag, " pulse"}, pv(), exp_p);
    if (exp_p != 0) check({tag, " level"}, {5'b0, cmd_level}, {5'b0, d[2:0]});
    @(negedge clk);
    check({tag, " pulse gone"}, pv(), 8'h00);
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mask", mask, 8'h00);
    check("R1 base", vec_base, 8'h00);
    check("R1 modes", {3'b0, nested_mode, auto_eoi, rot_aeoi, special_mask, lvl_clr_p}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    check("R1 trig", trig_mode, 8'h00);
    check("R1 pulses", pv(), 8'h00);

    // R2..R6 initialization with a fourth word
    wr(1'b1, 8'hFF);
    check("R6 mask load", mask, 8'hFF);
    wr(1'b0, 8'h11);
    check("R2 level clear pulse", {7'b0, lvl_clr_p}, 8'h01);
    check("R2 mask cleared", mask, 8'h00);
    wr(1'b1, 8'h45);
    check("R3 base", vec_base, 8'h40);
    wr(1'b1, 8'h99);
    check("R4 third word base", vec_base, 8'h40);
    check("R4 third word mask", mask, 8'h00);
    check("R4 third word modes", {6'b0, nested_mode, auto_eoi}, 8'h00);
    wr(1'b1, 8'h12);
    check("R5 nested+aeoi", {6'b0, nested_mode, auto_eoi}, 8'h03);
    check("R4 fourth word mask", mask, 8'h00);
    wr(1'b1, 8'h5A);
    check("R6 mask", mask, 8'h5A);
    rd(1'b1, 8'h5A, "R6 read mask");

    // R7 read select and special mask
    pend_i = 8'h33; insvc_i = 8'h81;
    rd(1'b0, 8'h33, "R7 default pending");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h81, "R7 in-service selected");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h81, "R7 select unchanged");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h33, "R7 pending selected");
    wr(1'b0, 8'h68);
    check("R7 special mask set", {7'b0, special_mask}, 8'h01);
    wr(1'b0, 8'h28);
    check("R7 special mask unchanged", {7'b0, special_mask}, 8'h01);
    wr(1'b0, 8'h48);
    check("R7 special mask clear", {7'b0, special_mask}, 8'h00);

    // R8 rotate-on-auto-EOI
    wr(1'b0, 8'h80);
    check("R8 rotate set", {7'b0, rot_aeoi}, 8'h01);
    wr(1'b0, 8'h00);
    check("R8 rotate clear", {7'b0, rot_aeoi}, 8'h00);

    // R9 command pulses: bits {ns,rot,spec,prio,rspec}
    cmd(8'h20, 8'h10, "R9 non-specific EOI");
    cmd(8'hA0, 8'h08, "R9 rotating EOI");
    cmd(8'h63, 8'h04, "R9 specific EOI");
    cmd(8'hC5, 8'h02, "R9 set priority");
    cmd(8'hE6, 8'h01, "R9 rotate-specific EOI");
    cmd(8'h40, 8'h00, "R9 code 2 no-op");

    // R10 poll with a winner, then normal read, then poll without winner
    win_valid_i = 1'b1; win_id_i = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h05, "R10 poll winner");
    check("R10 ack pulse", {7'b0, poll_ack_p}, 8'h01);
    check("R10 ack id", {5'b0, poll_ack_id}, 8'h05);
    rd(1'b0, 8'h33, "R10 poll cleared");
    check("R10 no ack on normal read", {7'b0, poll_ack_p}, 8'h00);
    win_valid_i = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b1, 8'h07, "R10 poll no winner");
    check("R10 no ack without winner", {7'b0, poll_ack_p}, 8'h00);

    // R2/R4 initialization without a fourth word
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h68);
    wr(1'b0, 8'h10);
    check("R2 modes cleared", {6'b0, nested_mode, auto_eoi}, 8'h00);
    check("R2 special mask cleared", {7'b0, special_mask}, 8'h00);
    wr(1'b1, 8'h0F);
    check("R3 base masked", vec_base, 8'h08);
    wr(1'b1, 8'hFF);
    check("R4 third word ignored", mask, 8'h00);
    wr(1'b1, 8'h3C);
    check("R4 no fourth word, mask", mask, 8'h3C);
    check("R4 modes stay clear", {6'b0, nested_mode, auto_eoi}, 8'h00);
    rd(1'b0, 8'h33, "R2 read select back to pending");

    // R11 trigger-mode register on master and slave instances
    @(negedge clk); trig_wr_en = 1'b1; trig_wdata = 8'hFF;
    @(negedge clk); trig_wr_en = 1'b0;
    check("R11 master trig", trig_mode, 8'hF8);
    check("R11 slave trig", s_trig, 8'hDE);
    @(negedge clk); trig_wr_en = 1'b1; trig_wdata = 8'h27;
    @(negedge clk); trig_wr_en = 1'b0;
    check("R11 master trig 2", trig_mode, 8'h20);
    check("R11 slave trig 2", s_trig, 8'h06);

    repeat (2) @(negedge clk);
    if (rd_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL unconsumed reads actual=%0d expected=0", rd_q.size());
    end
    finish_up();
  end
endmodule